// File: doc/BRIEF.md
# Priority Cell Pacing Scheduler

This block picks the channel that supplies the next outgoing ATM cell. It holds a small number of priority levels. Every level owns two sources of work. The first is a circular pacing table of channel slots, walked by a pointer that moves one slot per pacing period. The second is a first-in first-out bypass queue of channel numbers that skips pacing. A decision is taken only when the physical layer reports room for a cell and the consumer of the result can take it. The chosen channel, its level and its source then leave through a valid/ready handshake.

Each level has four control inputs: one switches its table off, one makes its table and queue share service evenly, one marks it as the lowest level that is examined, and one enables an interrupt for its table-overrun event. A table overrun means that the pointer moved on while the slot under it still held a channel that had never been issued. It sets a sticky per-level flag.

Top module: `cell_pace_sched`

## Requirements
- R1: A new result is loaded only in a cycle where `phy_tx_clav` is high and the output register is empty or being taken (`sel_valid` low or `sel_ready` high). While `sel_valid` is high and `sel_ready` is low, `sel_ch`, `sel_lvl` and `sel_from_tbl` hold their values.
- R2: Level 0 has the highest priority and larger level numbers rank lower. A decision serves the first level in that order that has either a queued channel or a pending table slot.
- R3: With `lvl_eq_share` clear for a level, that level's queue is drained before its table is served. `sel_from_tbl` is 0 for a queue result and 1 for a table result.
- R4: With `lvl_eq_share` set for a level, service at that level alternates between queue and table whenever both have work. After reset the queue goes first. After a queue service the table is next, and after a table service the queue is next.
- R5: With `lvl_tbl_off` set for a level, that level's table is never issued, its queue is still served, its share bit has no effect, and lower levels are still served.
- R6: Let k be the lowest-numbered level whose `lvl_last` bit is set. Levels above k are never selected. With no bit set, all levels take part.
- R7: Table slots hold a channel number, and the value 0 means an empty slot. Only the slot under the level's pointer can be issued, and it is issued at most once per visit. The pointer steps one slot per pacing period and wraps after the last slot.
- R8: The pacing period in clock cycles is `pace_period`, limited to at most 4094. A value of 0 acts as 1.
- R9: For a level whose table is on and which is not excluded by R6, `ovr_flag[l]` becomes 1 when the pointer leaves a nonzero slot that was never issued. The flag stays set until a cycle with `ovr_clr[l]` high. `ovr_irq` is the OR over levels of `ovr_flag & ovr_irq_en`.
- R10: Each bypass queue holds 4 channels in arrival order. A push into a full queue is discarded.
- R11: Changes to the control inputs affect only decisions made after the change. A result already waiting on the output does not change.
- R12: After reset, `sel_valid`, `ovr_flag` and `ovr_irq` are 0, all table slots are empty, all queues are empty and every pointer is at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pace_period | input | 12 | Pacing period in cycles, limited to 4094 |
| phy_tx_clav | input | 1 | Physical layer has room for a cell |
| tbl_wr_en | input | 1 | Write one table slot |
| tbl_wr_lvl | input | 2 | Level of the slot being written |
| tbl_wr_idx | input | 4 | Index of the slot being written |
| tbl_wr_ch | input | 8 | Channel to store (0 = empty) |
| q_push_en | input | 1 | Push a channel into a bypass queue |
| q_push_lvl | input | 2 | Level of the target queue |
| q_push_ch | input | 8 | Channel to push |
| lvl_tbl_off | input | 4 | Per-level table switch-off |
| lvl_eq_share | input | 4 | Per-level even queue/table sharing |
| lvl_last | input | 4 | Per-level lowest-examined marker |
| ovr_irq_en | input | 4 | Per-level overrun interrupt enable |
| ovr_clr | input | 4 | Per-level overrun flag clear |
| sel_valid | output | 1 | Result available |
| sel_ready | input | 1 | Consumer takes the result |
| sel_ch | output | 8 | Selected channel |
| sel_lvl | output | 2 | Level of the selected channel |
| sel_from_tbl | output | 1 | 1 when the result came from a table |
| ovr_flag | output | 4 | Sticky per-level overrun flags |
| ovr_irq | output | 1 | Enabled overrun interrupt |

## Verification
A wrong share toggle or a stale queue pointer shows up in the very next result. It appears as a channel out of order or a source bit flipped, so comparing whole result sequences against orders worked out from R2 to R7 finds it within a few cycles. A pointer or period counter that drifts by one cycle does not change any ordering. It only shifts when a table slot comes due, so the bench measures latency against several period values and compares the differences. A done bit that is not cleared, or that is cleared twice, shows either as a repeated channel within one slot visit or as a false or missing overrun flag one period later.

// File: rtl/cps_pkg.sv
package cps_pkg;

    localparam int CPS_LEVELS    = 4;
    localparam int CPS_CH_W      = 8;
    localparam int CPS_TBL_DEPTH = 16;
    localparam int CPS_Q_DEPTH   = 4;
    localparam int CPS_PER_W     = 12;
    localparam int CPS_PER_MAX   = 4094;

    typedef struct packed {
        logic tbl_off;
        logic eq_share;
        logic last;
        logic irq_en;
    } lvl_ctrl_t;

    typedef enum logic {
        SRC_QUEUE = 1'b0,
        SRC_TABLE = 1'b1
    } src_e;

    // Effective period: zero acts as one, anything above the cap is cut.
    function automatic logic [CPS_PER_W-1:0] cps_clamp_period(input logic [CPS_PER_W-1:0] p);
        if (p == '0)
            return CPS_PER_W'(1);
        if (p > CPS_PER_W'(CPS_PER_MAX))
            return CPS_PER_W'(CPS_PER_MAX);
        return p;
    endfunction

endpackage

// File: rtl/cps_pace_timer.sv
module cps_pace_timer
    import cps_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CPS_PER_W-1:0] period,
    output logic                 tick
);

    logic [CPS_PER_W-1:0] cnt;
    logic [CPS_PER_W-1:0] eff;

    assign eff  = cps_clamp_period(period);
    assign tick = (cnt >= eff - 1'b1);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assert_period_cap_R8: assert property (@(posedge clk) disable iff (rst)
        cnt < CPS_PER_W'(CPS_PER_MAX));

endmodule

// File: rtl/cps_chan_fifo.sv
module cps_chan_fifo #(
    parameter int DEPTH = 4,
    parameter int CH_W  = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic [CH_W-1:0] push_ch,
    input  logic            pop,
    output logic [CH_W-1:0] head,
    output logic            nonempty
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

    logic [CH_W-1:0] mem [DEPTH];
    logic [PW-1:0]   wr_ptr;
    logic [PW-1:0]   rd_ptr;
    logic [CW-1:0]   count;
    logic            full;
    logic            do_push;
    logic            do_pop;

    assign full     = (count == CW'(DEPTH));
    assign nonempty = (count != '0);
    assign do_push  = push && !full;
    assign do_pop   = pop && nonempty;
    assign head     = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= push_ch;
                wr_ptr      <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_full_drop_R10: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (count == $past(count)));

    assert_pop_nonempty_R10: assert property (@(posedge clk) disable iff (rst)
        pop |-> nonempty);

endmodule

// File: rtl/cps_pace_table.sv
module cps_pace_table #(
    parameter int DEPTH = 16,
    parameter int CH_W  = 8,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [CH_W-1:0] wr_ch,
    input  logic            issue,
    input  logic            watch,
    input  logic            clr,
    output logic            pending,
    output logic [CH_W-1:0] cur_ch,
    output logic            ovr
);

    localparam logic [IW-1:0] PTR_LAST = IW'(DEPTH - 1);

    logic [CH_W-1:0] slot [DEPTH];
    logic [IW-1:0]   ptr;
    logic            done;

    assign cur_ch  = slot[ptr];
    assign pending = (cur_ch != '0) && !done;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr  <= '0;
            done <= 1'b0;
            ovr  <= 1'b0;
            for (int i = 0; i < DEPTH; i++)
                slot[i] <= '0;
        end else begin
            if (wr_en)
                slot[wr_idx] <= wr_ch;
            if (tick) begin
                ptr  <= (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
                done <= 1'b0;
            end else if (issue) begin
                done <= 1'b1;
            end
            if (tick && watch && pending && !issue)
                ovr <= 1'b1;
            else if (clr)
                ovr <= 1'b0;
        end
    end

    assert_issue_pending_R7: assert property (@(posedge clk) disable iff (rst)
        issue |-> pending);

    assert_once_per_visit_R7: assert property (@(posedge clk) disable iff (rst)
        (issue && !tick) |=> !pending);

    assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (ovr && !clr) |=> ovr);

endmodule

// File: rtl/cps_level_arb.sv
module cps_level_arb #(
    parameter int LEVELS = 4,
    parameter int LW     = 2
) (
    input  logic [LEVELS-1:0] q_rdy,
    input  logic [LEVELS-1:0] t_rdy,
    input  logic [LEVELS-1:0] eq,
    input  logic [LEVELS-1:0] turn,
    input  logic [LEVELS-1:0] last,
    output logic              any,
    output logic [LW-1:0]     lvl,
    output logic              from_tbl,
    output logic [LEVELS-1:0] in_range
);

    always_comb begin
        logic stop;
        stop     = 1'b0;
        any      = 1'b0;
        lvl      = '0;
        from_tbl = 1'b0;
        for (int l = 0; l < LEVELS; l++) begin
            in_range[l] = !stop;
            if (!stop && !any && (q_rdy[l] || t_rdy[l])) begin
                any      = 1'b1;
                lvl      = LW'(l);
                from_tbl = t_rdy[l] && (!q_rdy[l] || (eq[l] && turn[l]));
            end
            if (last[l])
                stop = 1'b1;
        end
    end

endmodule

// File: rtl/cell_pace_sched.sv
module cell_pace_sched
    import cps_pkg::*;
#(
    parameter int LEVELS    = CPS_LEVELS,
    parameter int CH_W      = CPS_CH_W,
    parameter int TBL_DEPTH = CPS_TBL_DEPTH,
    parameter int Q_DEPTH   = CPS_Q_DEPTH,
    localparam int LW       = $clog2(LEVELS),
    localparam int IW       = $clog2(TBL_DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CPS_PER_W-1:0] pace_period,
    input  logic                 phy_tx_clav,
    input  logic                 tbl_wr_en,
    input  logic [LW-1:0]        tbl_wr_lvl,
    input  logic [IW-1:0]        tbl_wr_idx,
    input  logic [CH_W-1:0]      tbl_wr_ch,
    input  logic                 q_push_en,
    input  logic [LW-1:0]        q_push_lvl,
    input  logic [CH_W-1:0]      q_push_ch,
    input  logic [LEVELS-1:0]    lvl_tbl_off,
    input  logic [LEVELS-1:0]    lvl_eq_share,
    input  logic [LEVELS-1:0]    lvl_last,
    input  logic [LEVELS-1:0]    ovr_irq_en,
    input  logic [LEVELS-1:0]    ovr_clr,
    output logic                 sel_valid,
    input  logic                 sel_ready,
    output logic [CH_W-1:0]      sel_ch,
    output logic [LW-1:0]        sel_lvl,
    output logic                 sel_from_tbl,
    output logic [LEVELS-1:0]    ovr_flag,
    output logic                 ovr_irq
);

    lvl_ctrl_t         ctrl [LEVELS];
    logic              tick;
    logic [LEVELS-1:0] q_rdy, t_rdy, t_pend, turn, in_range;
    logic [LEVELS-1:0] v_off, v_eq, v_last, v_irq;
    logic [CH_W-1:0]   q_head [LEVELS];
    logic [CH_W-1:0]   t_ch   [LEVELS];
    logic              arb_any, arb_tbl, fire;
    logic [LW-1:0]     arb_lvl;
    src_e              arb_src;
    logic [CH_W-1:0]   next_ch;

    cps_pace_timer u_timer (
        .clk    (clk),
        .rst    (rst),
        .period (pace_period),
        .tick   (tick)
    );

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        logic hit, pop, issue, twr, qpush;

        assign ctrl[l] = '{tbl_off: lvl_tbl_off[l], eq_share: lvl_eq_share[l],
                           last: lvl_last[l], irq_en: ovr_irq_en[l]};
        assign v_off[l]  = ctrl[l].tbl_off;
        assign v_eq[l]   = ctrl[l].eq_share;
        assign v_last[l] = ctrl[l].last;
        assign v_irq[l]  = ctrl[l].irq_en;

        assign hit   = fire && (arb_lvl == LW'(l));
        assign pop   = hit && (arb_src == SRC_QUEUE);
        assign issue = hit && (arb_src == SRC_TABLE);
        assign twr   = tbl_wr_en && (tbl_wr_lvl == LW'(l));
        assign qpush = q_push_en && (q_push_lvl == LW'(l));
        assign t_rdy[l] = t_pend[l] && !v_off[l];

        cps_chan_fifo #(.DEPTH(Q_DEPTH), .CH_W(CH_W)) u_q (
            .clk      (clk),
            .rst      (rst),
            .push     (qpush),
            .push_ch  (q_push_ch),
            .pop      (pop),
            .head     (q_head[l]),
            .nonempty (q_rdy[l])
        );

        cps_pace_table #(.DEPTH(TBL_DEPTH), .CH_W(CH_W), .IW(IW)) u_tbl (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .wr_en   (twr),
            .wr_idx  (tbl_wr_idx),
            .wr_ch   (tbl_wr_ch),
            .issue   (issue),
            .watch   (in_range[l] && !v_off[l]),
            .clr     (ovr_clr[l]),
            .pending (t_pend[l]),
            .cur_ch  (t_ch[l]),
            .ovr     (ovr_flag[l])
        );

        // Share toggle: after a queue service the table is next, and vice versa.
        always_ff @(posedge clk) begin
            if (rst)
                turn[l] <= 1'b0;
            else if (hit)
                turn[l] <= (arb_src == SRC_QUEUE);
        end
    end

    cps_level_arb #(.LEVELS(LEVELS), .LW(LW)) u_arb (
        .q_rdy    (q_rdy),
        .t_rdy    (t_rdy),
        .eq       (v_eq),
        .turn     (turn),
        .last     (v_last),
        .any      (arb_any),
        .lvl      (arb_lvl),
        .from_tbl (arb_tbl),
        .in_range (in_range)
    );

    assign arb_src = arb_tbl ? SRC_TABLE : SRC_QUEUE;
    assign fire    = phy_tx_clav && (!sel_valid || sel_ready) && arb_any;
    assign next_ch = (arb_src == SRC_TABLE) ? t_ch[arb_lvl] : q_head[arb_lvl];
    assign ovr_irq = |(ovr_flag & v_irq);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_valid    <= 1'b0;
            sel_ch       <= '0;
            sel_lvl      <= '0;
            sel_from_tbl <= 1'b0;
        end else if (fire) begin
            sel_valid    <= 1'b1;
            sel_ch       <= next_ch;
            sel_lvl      <= arb_lvl;
            sel_from_tbl <= (arb_src == SRC_TABLE);
        end else if (sel_ready) begin
            sel_valid    <= 1'b0;
        end
    end

    assert_hold_stable_R1: assert property (@(posedge clk) disable iff (rst)
        (sel_valid && !sel_ready) |=>
            (sel_valid && $stable(sel_ch) && $stable(sel_lvl) && $stable(sel_from_tbl)));

    assert_no_clav_no_result_R1: assert property (@(posedge clk) disable iff (rst)
        (!phy_tx_clav && !sel_valid) |=> !sel_valid);

    assert_off_table_unused_R5: assert property (@(posedge clk) disable iff (rst)
        (fire && arb_tbl) |-> !lvl_tbl_off[arb_lvl]);

    assert_top_last_only_R6: assert property (@(posedge clk) disable iff (rst)
        (fire && lvl_last[0]) |=> (sel_lvl == '0));

endmodule

// File: tb/cell_pace_sched_tb.sv
`timescale 1ns/1ps
module cell_pace_sched_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] pace_period = 12'd4000;
    logic        phy_tx_clav = 1'b0;
    logic        tbl_wr_en = 1'b0;
    logic [1:0]  tbl_wr_lvl = '0;
    logic [3:0]  tbl_wr_idx = '0;
    logic [7:0]  tbl_wr_ch = '0;
    logic        q_push_en = 1'b0;
    logic [1:0]  q_push_lvl = '0;
    logic [7:0]  q_push_ch = '0;
    logic [3:0]  lvl_tbl_off = '0, lvl_eq_share = '0, lvl_last = '0;
    logic [3:0]  ovr_irq_en = '0, ovr_clr = '0;
    logic        sel_valid, sel_ready = 1'b1;
    logic [7:0]  sel_ch;
    logic [1:0]  sel_lvl;
    logic        sel_from_tbl;
    logic [3:0]  ovr_flag;
    logic        ovr_irq;

    int checks = 0;
    int errors = 0;
    int rc_n;
    int rc_ch [16];
    int rc_lvl [16];
    int rc_src [16];

    always #4 clk = ~clk;

    cell_pace_sched dut_i (
        .clk(clk), .rst(rst), .pace_period(pace_period), .phy_tx_clav(phy_tx_clav),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_lvl(tbl_wr_lvl), .tbl_wr_idx(tbl_wr_idx),
        .tbl_wr_ch(tbl_wr_ch), .q_push_en(q_push_en), .q_push_lvl(q_push_lvl),
        .q_push_ch(q_push_ch), .lvl_tbl_off(lvl_tbl_off), .lvl_eq_share(lvl_eq_share),
        .lvl_last(lvl_last), .ovr_irq_en(ovr_irq_en), .ovr_clr(ovr_clr),
        .sel_valid(sel_valid), .sel_ready(sel_ready), .sel_ch(sel_ch),
        .sel_lvl(sel_lvl), .sel_from_tbl(sel_from_tbl), .ovr_flag(ovr_flag),
        .ovr_irq(ovr_irq)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(int p);
        @(negedge clk);
        rst = 1'b1; pace_period = 12'(p); phy_tx_clav = 1'b0; sel_ready = 1'b1;
        lvl_tbl_off = '0; lvl_eq_share = '0; lvl_last = '0; ovr_irq_en = '0; ovr_clr = '0;
        cyc(2);
        rst = 1'b0;
    endtask

    task automatic wr_tbl(int l, int idx, int ch);
        tbl_wr_en = 1'b1; tbl_wr_lvl = 2'(l); tbl_wr_idx = 4'(idx); tbl_wr_ch = 8'(ch);
        cyc(1);
        tbl_wr_en = 1'b0;
    endtask

    task automatic push(int l, int ch);
        q_push_en = 1'b1; q_push_lvl = 2'(l); q_push_ch = 8'(ch);
        cyc(1);
        q_push_en = 1'b0;
    endtask

    task automatic collect(int n, int tmo);
        rc_n = 0;
        for (int c = 0; c < tmo && rc_n < n; c++) begin
            if (sel_valid) begin
                rc_ch[rc_n] = sel_ch; rc_lvl[rc_n] = sel_lvl; rc_src[rc_n] = sel_from_tbl;
                rc_n++;
            end
            cyc(1);
        end
    endtask

    task automatic expect_idle(string req, int n);
        int seen = 0;
        for (int c = 0; c < n; c++) begin
            if (sel_valid) seen++;
            cyc(1);
        end
        check(req, "results while idle expected", seen, 0);
    endtask

    task automatic expect_item(string req, int i, int ch, int lvl, int src);
        check(req, $sformatf("item %0d channel", i), rc_ch[i], ch);
        check(req, $sformatf("item %0d level", i), rc_lvl[i], lvl);
        check(req, $sformatf("item %0d source", i), rc_src[i], src);
    endtask

    task automatic measure(int p, output int lat);
        do_reset(p);
        wr_tbl(0, 1, 8'h31);
        phy_tx_clav = 1'b1;
        lat = 0;
        while (!sel_valid && lat < 5000) begin
            cyc(1);
            lat++;
        end
        check("R8", "channel after period", sel_ch, 8'h31);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int l0, l1, l2, l3;

        // R12: reset state
        @(negedge clk); cyc(2);
        check("R12", "sel_valid in reset", sel_valid, 0);
        check("R12", "ovr_flag in reset", ovr_flag, 0);
        check("R12", "ovr_irq in reset", ovr_irq, 0);

        // R1/R2: no result without clav, then strict level order
        do_reset(4000);
        push(2, 8'h21); push(0, 8'h01); push(1, 8'h11);
        cyc(3);
        check("R1", "valid with clav low", sel_valid, 0);
        phy_tx_clav = 1'b1;
        collect(3, 20);
        check("R2", "result count", rc_n, 3);
        expect_item("R2", 0, 8'h01, 0, 0);
        expect_item("R2", 1, 8'h11, 1, 0);
        expect_item("R2", 2, 8'h21, 2, 0);

        // R3: queue before table without share
        do_reset(4000);
        wr_tbl(0, 0, 8'h0A); push(0, 8'h0B); push(0, 8'h0C);
        phy_tx_clav = 1'b1;
        collect(3, 20);
        expect_item("R3", 0, 8'h0B, 0, 0);
        expect_item("R3", 1, 8'h0C, 0, 0);
        expect_item("R3", 2, 8'h0A, 0, 1);

        // R4: alternate with share set
        do_reset(4000);
        lvl_eq_share = 4'b0001;
        wr_tbl(0, 0, 8'h0A); push(0, 8'h0B); push(0, 8'h0C);
        phy_tx_clav = 1'b1;
        collect(3, 20);
        expect_item("R4", 0, 8'h0B, 0, 0);
        expect_item("R4", 1, 8'h0A, 0, 1);
        expect_item("R4", 2, 8'h0C, 0, 0);

        // R5: table off, share ignored, lower level still served
        do_reset(4000);
        lvl_tbl_off = 4'b0001; lvl_eq_share = 4'b0001;
        wr_tbl(0, 0, 8'h0A); wr_tbl(1, 0, 8'h1A); push(0, 8'h0B); push(0, 8'h0C);
        phy_tx_clav = 1'b1;
        collect(3, 20);
        expect_item("R5", 0, 8'h0B, 0, 0);
        expect_item("R5", 1, 8'h0C, 0, 0);
        expect_item("R5", 2, 8'h1A, 1, 1);
        expect_idle("R5", 10);

        // R6/R11: levels past the last marker ignored until it is cleared
        do_reset(4000);
        lvl_last = 4'b0010;
        push(2, 8'h2A); push(3, 8'h3A); push(0, 8'h0A);
        phy_tx_clav = 1'b1;
        collect(1, 10);
        expect_item("R6", 0, 8'h0A, 0, 0);
        expect_idle("R6", 10);
        lvl_last = 4'b0000;
        collect(2, 10);
        check("R11", "results after control change", rc_n, 2);
        expect_item("R6", 0, 8'h2A, 2, 0);
        expect_item("R6", 1, 8'h3A, 3, 0);

        // R10: queue depth and full drop
        do_reset(4000);
        for (int i = 0; i < 5; i++) push(1, 8'h50 + i);
        phy_tx_clav = 1'b1;
        collect(5, 20);
        check("R10", "results from full queue", rc_n, 4);
        for (int i = 0; i < 4; i++) expect_item("R10", i, 8'h50 + i, 1, 0);

        // R1/R11: hold under back-pressure, control change does not alter the waiting result
        do_reset(4000);
        sel_ready = 1'b0; phy_tx_clav = 1'b1;
        push(0, 8'h61); push(0, 8'h62);
        cyc(3);
        check("R1", "valid under back-pressure", sel_valid, 1);
        check("R1", "held channel", sel_ch, 8'h61);
        lvl_last = 4'b1111; lvl_eq_share = 4'b1111; lvl_tbl_off = 4'b1111;
        cyc(3);
        check("R11", "held channel after control change", sel_ch, 8'h61);
        check("R11", "held level after control change", sel_lvl, 0);
        lvl_last = '0; lvl_eq_share = '0; lvl_tbl_off = '0;
        sel_ready = 1'b1;
        cyc(1);
        check("R1", "next channel after take", sel_ch, 8'h62);

        // R7: empty current slot and non-current slot are not issued
        do_reset(4000);
        wr_tbl(0, 5, 8'h55);
        phy_tx_clav = 1'b1;
        expect_idle("R7", 10);

        // R7/R9: slot walk, one issue per visit, no overrun when issued
        do_reset(20);
        for (int i = 0; i < 4; i++) wr_tbl(0, i, 8'h41 + i);
        phy_tx_clav = 1'b1;
        collect(4, 150);
        check("R7", "walk result count", rc_n, 4);
        for (int i = 0; i < 4; i++) expect_item("R7", i, 8'h41 + i, 0, 1);
        expect_idle("R7", 100);
        check("R9", "no overrun when issued", ovr_flag, 0);

        // R9: overrun flag, enable, clear, exclusions
        do_reset(6);
        lvl_tbl_off = 4'b0010; lvl_last = 4'b0010;
        wr_tbl(0, 0, 8'h71); wr_tbl(1, 0, 8'h72); wr_tbl(2, 0, 8'h73);
        cyc(10);
        check("R9", "overrun flags", ovr_flag, 4'b0001);
        check("R9", "irq masked", ovr_irq, 0);
        ovr_irq_en = 4'b0001;
        cyc(1);
        check("R9", "irq enabled", ovr_irq, 1);
        ovr_clr = 4'b0001;
        cyc(1);
        ovr_clr = 4'b0000;
        check("R9", "flag after clear", ovr_flag, 0);
        check("R9", "irq after clear", ovr_irq, 0);

        // R8: period latency differences and cap
        measure(100, l0);
        measure(4093, l1);
        measure(4094, l2);
        measure(4095, l3);
        check("R8", "latency 4094 minus 100", l2 - l0, 3994);
        check("R8", "latency 4094 minus 4093", l2 - l1, 1);
        check("R8", "latency 4095 equals 4094", l3, l2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule